// File: doc/BRIEF.md
# Shadowed PLL Control Register File

This block is a small memory-mapped register file placed between a processor register bus and a clock PLL. Software writes the wanted PLL control bits (enable, connect) and the multiplier and divider into two holding registers. Those values do not reach the PLL until software performs an unlock sequence of two writes to a dedicated key register. That sequence copies both holding registers into the active shadow registers in a single clock edge. A single stray write therefore cannot reconfigure the clock.

A read-only status register reports what the PLL is really being driven with: the active shadow values plus the lock flag from the PLL. The intended software order is: program the configuration, enable, wait for the lock flag, then set connect. The connect output only rises when the shadow enable and connect bits are both set and the PLL reports lock. A power-down input clears the active enable and connect bits, which leaves the PLL off and bypassed. The contents of the holding registers are kept.

Top module: `pll_shadow_regs`

## Requirements
- R1: While reset is high and after it is released, all outputs are 0 and every register reads 0.
- R2: The control register (byte offset 0x00, word index 0) keeps wdata[1:0] (bit 0 enable, bit 1 connect). The configuration register (offset 0x04) keeps wdata[6:0] (bits [4:0] multiplier, bits [6:5] divider). Unused bits read as 0.
- R3: Writes to the control or configuration register change no output and no status bit until a valid feed completes.
- R4: A valid feed is a write with wdata[7:0]=0xAA to offset 0x0C, followed by a write with wdata[7:0]=0x55 to offset 0x0C. Non-write cycles may separate the two writes. The edge of the second write copies both holding registers into the shadow registers. pll_en_o, mul_o and div_o follow that copy from the same edge.
- R5: Any write between the two key writes aborts the sequence. This includes a write to another register and a write of a wrong value to offset 0x0C. A lone 0x55 write commits nothing.
- R6: pll_conn_o is a register that is set one clock after a cycle in which shadow enable, shadow connect and lock_i are all high, and cleared otherwise.
- R7: While pd_i is high, the shadow enable and connect bits are cleared at each edge. This overrides a commit in the same cycle. The configuration shadow still commits. Enable stays off after pd_i falls until the next feed.
- R8: Status (offset 0x08) reads {lock at bit 10, shadow connect at bit 8, shadow enable at bit 7, shadow configuration at bits [6:0]}. It ignores writes. Offset 0x0C reads 0.
- R9: rdata_o is registered: it shows the register addressed in the previous cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr_i | input | ADDR_W (4) | Byte address, word-aligned |
| wr_i | input | 1 | Write strobe |
| wdata_i | input | DATA_W (32) | Write data |
| rdata_o | output | DATA_W (32) | Registered read data |
| pd_i | input | 1 | Power-down request |
| lock_i | input | 1 | PLL lock indication |
| pll_en_o | output | 1 | Active PLL enable |
| pll_conn_o | output | 1 | PLL connect (use PLL as clock) |
| mul_o | output | MUL_W (5) | Active multiplier field |
| div_o | output | DIV_W (2) | Active divider field |

## Verification
The feed commit and power-down can land on the same edge. The bench holds pd_i high while the 0x55 key write occurs. It then expects the new multiplier in mul_o and in the status read, with pll_en_o still low, and pll_en_o still low after pd_i falls. A second overlap is between an armed sequence and a stray write to another register. The bench judges it by confirming that the following 0x55 leaves pll_en_o and the status word unchanged.

// File: rtl/pll_regs_pkg.sv
package pll_regs_pkg;
  localparam int IDX_CTL  = 0;
  localparam int IDX_CFG  = 1;
  localparam int IDX_STAT = 2;
  localparam int IDX_FEED = 3;
  localparam int CTL_W    = 2;
  localparam int BIT_EN   = 0;
  localparam int BIT_CONN = 1;

  typedef enum logic {
    FEED_IDLE  = 1'b0,
    FEED_ARMED = 1'b1
  } feed_st_e;
endpackage

// File: rtl/pll_feed_seq.sv
module pll_feed_seq
  import pll_regs_pkg::*;
#(
  parameter int IDX_W = 2,
  parameter int KEY_W = 8,
  parameter logic [KEY_W-1:0] KEY_ARM  = 8'hAA,
  parameter logic [KEY_W-1:0] KEY_FIRE = 8'h55
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_i,
  input  logic [IDX_W-1:0] idx_i,
  input  logic [KEY_W-1:0] key_i,
  output logic             commit_o
);
  feed_st_e st_q, st_d;
  logic     feed_hit;

  assign feed_hit = wr_i && (idx_i == IDX_W'(IDX_FEED));

  always_comb begin
    st_d     = st_q;
    commit_o = 1'b0;
    if (wr_i) begin
      if (feed_hit && key_i == KEY_ARM) begin
        st_d = FEED_ARMED;
      end else if (feed_hit && key_i == KEY_FIRE && st_q == FEED_ARMED) begin
        st_d     = FEED_IDLE;
        commit_o = 1'b1;
      end else begin
        st_d = FEED_IDLE;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) st_q <= FEED_IDLE;
    else     st_q <= st_d;
  end

  // R5: a write that is not a feed-register write leaves the sequence idle
  a_r5_stray_write_aborts: assert property (@(posedge clk) disable iff (rst)
    (wr_i && !feed_hit) |=> (st_q == FEED_IDLE));

  // R4: a commit consumes the armed state
  a_r4_commit_disarms: assert property (@(posedge clk) disable iff (rst)
    commit_o |=> (st_q == FEED_IDLE));
endmodule

// File: rtl/pll_shadow_bank.sv
module pll_shadow_bank
  import pll_regs_pkg::*;
#(
  parameter int IDX_W = 2,
  parameter int CFG_W = 7
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_i,
  input  logic [IDX_W-1:0] idx_i,
  input  logic [CFG_W-1:0] wdata_i,
  input  logic             commit_i,
  input  logic             pd_i,
  output logic [CTL_W-1:0] hold_ctl_o,
  output logic [CFG_W-1:0] hold_cfg_o,
  output logic [CTL_W-1:0] sh_ctl_o,
  output logic [CFG_W-1:0] sh_cfg_o
);
  always_ff @(posedge clk) begin
    if (rst) begin
      hold_ctl_o <= '0;
      hold_cfg_o <= '0;
      sh_ctl_o   <= '0;
      sh_cfg_o   <= '0;
    end else begin
      if (wr_i && idx_i == IDX_W'(IDX_CTL)) hold_ctl_o <= wdata_i[CTL_W-1:0];
      if (wr_i && idx_i == IDX_W'(IDX_CFG)) hold_cfg_o <= wdata_i;
      if (commit_i) begin
        sh_ctl_o <= hold_ctl_o;
        sh_cfg_o <= hold_cfg_o;
      end
      if (pd_i) sh_ctl_o <= '0;
    end
  end

  // R3: the active configuration only moves on a commit
  a_r3_cfg_holds_without_feed: assert property (@(posedge clk) disable iff (rst)
    !commit_i |=> $stable(sh_cfg_o));

  // R7: power-down leaves enable and connect cleared
  a_r7_pd_clears_ctl: assert property (@(posedge clk) disable iff (rst)
    pd_i |=> (sh_ctl_o == '0));
endmodule

// File: rtl/pll_read_mux.sv
module pll_read_mux
  import pll_regs_pkg::*;
#(
  parameter int IDX_W  = 2,
  parameter int DATA_W = 32,
  parameter int CFG_W  = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic [CTL_W-1:0]  hold_ctl_i,
  input  logic [CFG_W-1:0]  hold_cfg_i,
  input  logic [DATA_W-1:0] status_i,
  output logic [DATA_W-1:0] rdata_o
);
  logic [DATA_W-1:0] sel;

  always_comb begin
    sel = '0;
    case (idx_i)
      IDX_W'(IDX_CTL):  sel[CTL_W-1:0] = hold_ctl_i;
      IDX_W'(IDX_CFG):  sel[CFG_W-1:0] = hold_cfg_i;
      IDX_W'(IDX_STAT): sel = status_i;
      default:          sel = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) rdata_o <= '0;
    else     rdata_o <= sel;
  end

  // R8: the key register reads back as zero
  a_r8_feed_reads_zero: assert property (@(posedge clk) disable iff (rst)
    (idx_i == IDX_W'(IDX_FEED)) |=> (rdata_o == '0));
endmodule

// File: rtl/pll_shadow_regs.sv
module pll_shadow_regs
  import pll_regs_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int ADDR_W   = 4,
  parameter int MUL_W    = 5,
  parameter int DIV_W    = 2,
  parameter int LOCK_BIT = 10,
  parameter int KEY_W    = 8,
  parameter logic [KEY_W-1:0] KEY_ARM  = 8'hAA,
  parameter logic [KEY_W-1:0] KEY_FIRE = 8'h55
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic              pd_i,
  input  logic              lock_i,
  output logic              pll_en_o,
  output logic              pll_conn_o,
  output logic [MUL_W-1:0]  mul_o,
  output logic [DIV_W-1:0]  div_o
);
  localparam int CFG_W = MUL_W + DIV_W;
  localparam int IDX_W = ADDR_W - 2;

  logic [IDX_W-1:0]  idx;
  logic              commit;
  logic [CTL_W-1:0]  hold_ctl, sh_ctl;
  logic [CFG_W-1:0]  hold_cfg, sh_cfg;
  logic [DATA_W-1:0] status;
  logic              conn_q;
  logic              unused_bits;

  assign idx         = addr_i[ADDR_W-1:2];
  assign unused_bits = ^{addr_i[1:0], wdata_i};

  pll_feed_seq #(
    .IDX_W(IDX_W), .KEY_W(KEY_W), .KEY_ARM(KEY_ARM), .KEY_FIRE(KEY_FIRE)
  ) u_feed (
    .clk(clk), .rst(rst), .wr_i(wr_i), .idx_i(idx),
    .key_i(wdata_i[KEY_W-1:0]), .commit_o(commit)
  );

  pll_shadow_bank #(.IDX_W(IDX_W), .CFG_W(CFG_W)) u_bank (
    .clk(clk), .rst(rst), .wr_i(wr_i), .idx_i(idx),
    .wdata_i(wdata_i[CFG_W-1:0]), .commit_i(commit), .pd_i(pd_i),
    .hold_ctl_o(hold_ctl), .hold_cfg_o(hold_cfg),
    .sh_ctl_o(sh_ctl), .sh_cfg_o(sh_cfg)
  );

  always_comb begin
    status                    = '0;
    status[CFG_W-1:0]         = sh_cfg;
    status[CFG_W +: CTL_W]    = sh_ctl;
    status[LOCK_BIT]          = lock_i;
  end

  pll_read_mux #(.IDX_W(IDX_W), .DATA_W(DATA_W), .CFG_W(CFG_W)) u_rd (
    .clk(clk), .rst(rst), .idx_i(idx), .hold_ctl_i(hold_ctl),
    .hold_cfg_i(hold_cfg), .status_i(status), .rdata_o(rdata_o)
  );

  always_ff @(posedge clk) begin
    if (rst) conn_q <= 1'b0;
    else     conn_q <= sh_ctl[BIT_EN] & sh_ctl[BIT_CONN] & lock_i;
  end

  assign pll_en_o   = sh_ctl[BIT_EN];
  assign pll_conn_o = conn_q;
  assign mul_o      = sh_cfg[MUL_W-1:0];
  assign div_o      = sh_cfg[CFG_W-1:MUL_W];

  // R6: connect only follows a cycle with lock and shadow enable
  a_r6_conn_needs_lock: assert property (@(posedge clk) disable iff (rst)
    pll_conn_o |-> $past(lock_i && sh_ctl[BIT_EN]));

  // R1: reset clears the outputs
  a_r1_reset_clears: assert property (@(posedge clk)
    rst |=> (!pll_en_o && !pll_conn_o && rdata_o == '0));
endmodule

// File: tb/pll_shadow_regs_test.sv
module pll_shadow_regs_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  addr = '0;
  logic        wr = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        pd = 1'b0;
  logic        lock = 1'b0;
  logic        pll_en, pll_conn;
  logic [4:0]  mul;
  logic [1:0]  div;

  int vectors = 0;
  int miscompares = 0;
  logic issue = 1'b0;
  logic pipe = 1'b0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #2.5 clk = ~clk;

  pll_shadow_regs uut (
    .clk(clk), .rst(rst), .addr_i(addr), .wr_i(wr), .wdata_i(wdata),
    .rdata_o(rdata), .pd_i(pd), .lock_i(lock), .pll_en_o(pll_en),
    .pll_conn_o(pll_conn), .mul_o(mul), .div_o(div)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk); addr = a; wdata = d; wr = 1'b1; issue = 1'b0;
  endtask

  task automatic idle();
    @(negedge clk); wr = 1'b0; issue = 1'b0;
  endtask

  task automatic rd_reg(input logic [3:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk); addr = a; wr = 1'b0; issue = 1'b1;
    exp_q.push_back(exp); tag_q.push_back(tag);
  endtask

  task automatic feed();
    wr_reg(4'hC, 32'hAA); wr_reg(4'hC, 32'h55);
  endtask

  // monitor: a read issued in one cycle is compared one cycle later (R9)
  always @(posedge clk) pipe <= issue;
  always @(negedge clk) begin
    if (pipe && exp_q.size() > 0) chk(tag_q.pop_front(), rdata, exp_q.pop_front());
  end

  initial begin
    repeat (100000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    idle();
    chk("R1 en", {31'd0, pll_en}, 0);
    chk("R1 conn", {31'd0, pll_conn}, 0);
    chk("R1 mul/div", {25'd0, div, mul}, 0);
    rd_reg(4'h8, 32'h0, "R1 status");
    rd_reg(4'h0, 32'h0, "R1 ctl");

    // holding registers
    wr_reg(4'h0, 32'hFFFF_FFFF);
    wr_reg(4'h4, 32'h45);
    rd_reg(4'h0, 32'h3, "R2 ctl masked");
    rd_reg(4'h4, 32'h45, "R2 cfg");
    rd_reg(4'h8, 32'h0, "R3 status unchanged");
    chk("R3 en before feed", {31'd0, pll_en}, 0);
    chk("R3 mul before feed", {27'd0, mul}, 0);

    // valid feed with a read between the keys
    wr_reg(4'hC, 32'hAA);
    rd_reg(4'hC, 32'h0, "R8 feed reads zero");
    wr_reg(4'hC, 32'h55);
    idle();
    chk("R4 en", {31'd0, pll_en}, 1);
    chk("R4 mul", {27'd0, mul}, 5);
    chk("R4 div", {30'd0, div}, 2);
    chk("R6 conn no lock", {31'd0, pll_conn}, 0);
    lock = 1'b1;
    idle(); idle();
    chk("R6 conn with lock", {31'd0, pll_conn}, 1);
    rd_reg(4'h8, 32'h5C5, "R8 status layout");

    // aborted sequences
    wr_reg(4'h0, 32'h0);
    wr_reg(4'hC, 32'hAA); wr_reg(4'h4, 32'h1F); wr_reg(4'hC, 32'h55);
    idle();
    chk("R5 stray write aborts", {31'd0, pll_en}, 1);
    wr_reg(4'hC, 32'hAA); wr_reg(4'hC, 32'h56); wr_reg(4'hC, 32'h55);
    idle();
    chk("R5 wrong key aborts", {31'd0, pll_en}, 1);
    wr_reg(4'hC, 32'h55);
    idle();
    chk("R5 lone fire key", {27'd0, mul}, 5);

    // status ignores writes
    wr_reg(4'h8, 32'hFFFF_FFFF);
    rd_reg(4'h0, 32'h0, "R8 ctl after status write");
    rd_reg(4'h4, 32'h1F, "R8 cfg after status write");
    rd_reg(4'h8, 32'h5C5, "R8 status write ignored");

    feed(); idle();
    chk("R4 en cleared by commit", {31'd0, pll_en}, 0);
    chk("R4 mul 31", {27'd0, mul}, 31);
    chk("R4 div 0", {30'd0, div}, 0);

    // connect without enable
    wr_reg(4'h0, 32'h2); feed(); idle(); idle();
    chk("R6 conn needs enable", {31'd0, pll_conn}, 0);

    // power-down
    wr_reg(4'h0, 32'h3); wr_reg(4'h4, 32'h22); feed(); idle(); idle();
    chk("R6 conn up", {31'd0, pll_conn}, 1);
    pd = 1'b1;
    idle();
    chk("R7 pd clears en", {31'd0, pll_en}, 0);
    idle();
    chk("R7 pd drops conn", {31'd0, pll_conn}, 0);
    chk("R7 cfg kept", {25'd0, div, mul}, 32'h22);
    wr_reg(4'h4, 32'h0A); feed(); idle();
    chk("R7 commit under pd en", {31'd0, pll_en}, 0);
    chk("R7 commit under pd mul", {27'd0, mul}, 10);
    pd = 1'b0;
    idle(); idle();
    chk("R7 en stays off", {31'd0, pll_en}, 0);
    rd_reg(4'h8, 32'h40A, "R7 status after pd");
    idle(); idle();

    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule